// File: doc/BRIEF.md
# EDO DRAM Controller with Timed Refresh

This block connects a simple word-oriented request port to a 1M x 16 asynchronous extended-data-out DRAM. A requester presents a 20-bit word address, a write flag, 16 bits of write data and two byte enables under a valid/ready handshake. Reads return the whole word on a data bus that is qualified by a one-cycle valid pulse. On the memory side the controller multiplexes the upper ten address bits (row) and the lower ten (column) onto one 10-bit address bus. It generates the active-low row strobe, the two active-low column strobes (one per byte lane), the write enable and the output enable. The bidirectional data bus is split into an output word, an output enable and an input word.

After an access the row stays open. A later request to the same row needs only a new column and a column strobe pulse, and the row strobe stays low. A request to a different row first closes the open row and waits out the precharge time. A free-running timer raises a refresh request once per row interval (the refresh period divided by the number of rows). The refresh runs before any further user request: the controller closes any open row, drops both column strobes and then drops the row strobe, so the memory supplies the row from its own counter. Every timing limit is a parameter given in nanoseconds and rounded up to whole clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During and right after reset, all five memory strobes are high, `dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: When the row strobe falls for a user access, `mem_addr` carries `req_addr[19:10]`. When a column strobe falls, it carries `req_addr[9:0]`.
- R3: A write asserts `mem_casl_n` (data bits 7:0) only if `req_be[0]` is 1, and `mem_cash_n` (data bits 15:8) only if `req_be[1]` is 1. Bytes whose enable is 0 keep their old value, and a write with `req_be` = 2'b00 changes nothing.
- R4: When both lanes take part in an access, the two column strobes fall in the same cycle and rise in the same cycle.
- R5: Write enable is low at least one cycle before a column strobe falls for a write. `dq_oe` is high only while write enable is low and output enable is high. Output enable is never low together with write enable.
- R6: A read asserts both column strobes and returns the full stored word on `rd_data` with `rd_valid` high for exactly one cycle.
- R7: A request to the row that is already open does not toggle the row strobe.
- R8: A request to a different row raises the row strobe and keeps it high for at least the precharge count before it falls again.
- R9: A refresh drives both column strobes low at least one cycle before the row strobe falls. Refreshes follow each other, and the first follows reset, within the row interval plus the worst-case length of one access.
- R10: A pending refresh is served before any further user request, even under back-to-back traffic. Before a refresh, any open row is closed for at least the precharge count.
- R11: A column strobe stays low for at least the larger of the column access count, the minimum strobe width and the column-address access count less one. Read data is sampled no earlier than the row access count after the row strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: [19:10] row, [9:0] column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_casl_n | output | 1 | Low-byte column strobe, active low |
| mem_cash_n | output | 1 | High-byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 10 | Multiplexed row/column address |
| dq_out | output | 16 | Data driven to the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 16 | Data returned by the memory |

## Verification
The assertions assume that `dq_in` holds the addressed word from the cycle after a column strobe falls with output enable low, for as long as that strobe stays low. They also assume that request fields stay stable while `req_valid` waits for `req_ready`. The bench's memory model updates `dq_in` right at the column strobe edge, and the bench changes request fields only at falling clock edges. It holds each request until the first rising edge where `req_ready` was high. Traffic is confined to a few rows so that page hits, row misses and refresh collisions all occur.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_ROW_ADDR,
    S_ROW_WAIT,
    S_COL_SETUP,
    S_COL_STROBE,
    S_REF_CAS,
    S_REF_RAS,
    S_REF_PRE
  } seq_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      pend <= (pend & ~ack) | tick;
    end
  end

  // a request is never dropped without being served
  p_pend_held_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] cur_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (set) begin
      is_open <= 1'b1;
      cur_row <= set_row;
    end else if (clr) begin
      is_open <= 1'b0;
    end
  end

  assign hit = is_open && (cur_row == probe_row);

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RAC_NS = 50,
  parameter int T_PC_NS  = 20,
  parameter int T_AA_NS  = 25,
  parameter int T_CAC_NS = 15,
  parameter int T_CAS_NS = 8,
  parameter int T_RP_NS  = 30,
  parameter int T_RAS_NS = 50
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_be,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  input  logic                     ref_pend,
  output logic                     ref_ack,
  input  logic                     row_open,
  input  logic                     row_hit,
  output logic                     row_set,
  output logic                     row_clr,
  output logic [ROW_W-1:0]         row_val,
  output logic                     ras_n,
  output logic [DATA_W/8-1:0]      cas_n,
  output logic                     we_n,
  output logic                     oe_n,
  output logic [maxi(ROW_W,COL_W)-1:0] mem_addr,
  output logic [DATA_W-1:0]        dq_out,
  output logic                     dq_oe,
  input  logic [DATA_W-1:0]        dq_in
);
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int LANES   = DATA_W / 8;
  localparam int MA_W    = maxi(ROW_W, COL_W);
  localparam int CAS_CYC = maxi(maxi(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_CAS_NS, CLK_NS)),
                                maxi(ns2cyc(T_AA_NS, CLK_NS) - 1, 1));
  localparam int RCD_CYC = maxi(ns2cyc(T_RAC_NS, CLK_NS) - CAS_CYC - 1, 1);
  localparam int CP_CYC  = maxi(ns2cyc(T_PC_NS, CLK_NS) - CAS_CYC, 1);
  localparam int RP_CYC  = maxi(ns2cyc(T_RP_NS, CLK_NS), 1);
  localparam int RAS_CYC = maxi(ns2cyc(T_RAS_NS, CLK_NS), 1);
  localparam int CNT_MAX = maxi(maxi(CAS_CYC, RCD_CYC), maxi(maxi(CP_CYC, RP_CYC), RAS_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic              lat_we;
  logic [LANES-1:0]  lat_be;
  logic              pre_ref;
  logic              cnt_done;

  assign cnt_done  = (cnt == '0);
  assign req_ready = (state == S_IDLE) && !ref_pend;
  assign ref_ack   = (state == S_REF_CAS);
  assign row_set   = (state == S_ROW_ADDR);
  assign row_clr   = (state == S_PRE) || (state == S_REF_CAS);
  assign row_val   = lat_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
      lat_we   <= 1'b0;
      lat_be   <= '0;
      pre_ref  <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= '1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              ras_n   <= 1'b1;
              cnt     <= CNT_W'(RP_CYC - 1);
              pre_ref <= 1'b1;
              state   <= S_PRE;
            end else begin
              cas_n <= '0;
              state <= S_REF_CAS;
            end
          end else if (req_valid) begin
            lat_row <= req_addr[ADDR_W-1:COL_W];
            lat_col <= req_addr[COL_W-1:0];
            lat_we  <= req_we;
            lat_be  <= req_we ? req_be : '1;
            dq_out  <= req_wdata;
            if (row_hit) begin
              mem_addr <= MA_W'(req_addr[COL_W-1:0]);
              we_n     <= ~req_we;
              oe_n     <= req_we;
              dq_oe    <= req_we;
              cnt      <= CNT_W'(CP_CYC - 1);
              state    <= S_COL_SETUP;
            end else if (row_open) begin
              ras_n   <= 1'b1;
              cnt     <= CNT_W'(RP_CYC - 1);
              pre_ref <= 1'b0;
              state   <= S_PRE;
            end else begin
              mem_addr <= MA_W'(req_addr[ADDR_W-1:COL_W]);
              state    <= S_ROW_ADDR;
            end
          end
        end
        S_PRE: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (pre_ref) begin
            cas_n <= '0;
            state <= S_REF_CAS;
          end else begin
            mem_addr <= MA_W'(lat_row);
            state    <= S_ROW_ADDR;
          end
        end
        S_ROW_ADDR: begin
          ras_n <= 1'b0;
          cnt   <= CNT_W'(RCD_CYC - 1);
          state <= S_ROW_WAIT;
        end
        S_ROW_WAIT: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin
            mem_addr <= MA_W'(lat_col);
            we_n     <= ~lat_we;
            oe_n     <= lat_we;
            dq_oe    <= lat_we;
            cnt      <= '0;
            state    <= S_COL_SETUP;
          end
        end
        S_COL_SETUP: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin
            cas_n <= ~lat_be;
            cnt   <= CNT_W'(CAS_CYC - 1);
            state <= S_COL_STROBE;
          end
        end
        S_COL_STROBE: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin
            cas_n <= '1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (!lat_we) begin
              rd_data  <= dq_in;
              rd_valid <= 1'b1;
            end
            state <= S_IDLE;
          end
        end
        S_REF_CAS: begin
          ras_n <= 1'b0;
          cnt   <= CNT_W'(RAS_CYC - 1);
          state <= S_REF_RAS;
        end
        S_REF_RAS: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else begin
            ras_n <= 1'b1;
            cas_n <= '1;
            cnt   <= CNT_W'(RP_CYC - 1);
            state <= S_REF_PRE;
          end
        end
        S_REF_PRE: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [CNT_W-1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) ras_hi_cnt <= CNT_W'(RP_CYC);
    else if (!ras_n) ras_hi_cnt <= '0;
    else if (ras_hi_cnt < CNT_W'(RP_CYC)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (ras_hi_cnt >= CNT_W'(RP_CYC)));

  p_cbr_order_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && (cas_n != '1)) |-> ((cas_n == '0) && $past(cas_n == '0)));

  p_we_setup_r5: assert property (@(posedge clk) disable iff (rst)
    ((cas_n & ~$past(cas_n)) == '0 && (cas_n != $past(cas_n)) && !we_n) |-> $past(!we_n));

  p_drive_dir_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (oe_n && !we_n));

  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  p_read_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && (cas_n != '1)) |-> (cas_n == '0));

  p_hit_keeps_row_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && row_hit) |=> !ras_n);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 10,
  parameter int T_RAC_NS   = 50,
  parameter int T_PC_NS    = 20,
  parameter int T_AA_NS    = 25,
  parameter int T_CAC_NS   = 15,
  parameter int T_CAS_NS   = 8,
  parameter int T_RP_NS    = 30,
  parameter int T_RAS_NS   = 50,
  parameter int T_REFW_NS  = 16_000_000,
  parameter int REF_ROWS   = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   mem_ras_n,
  output logic                   mem_casl_n,
  output logic                   mem_cash_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [maxi(ROW_W,COL_W)-1:0] mem_addr,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_oe,
  input  logic [DATA_W-1:0]      dq_in
);
  localparam int LANES   = DATA_W / 8;
  localparam int REF_CYC = maxi((T_REFW_NS / REF_ROWS) / CLK_NS, 2);

  logic             ref_pend, ref_ack;
  logic             row_open, row_hit, row_set, row_clr;
  logic [ROW_W-1:0] row_val;
  logic [LANES-1:0] cas_n;

  edo_ref_timer #(.INTERVAL(REF_CYC)) i_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  edo_row_track #(.ROW_W(ROW_W)) i_rows (
    .clk(clk), .rst(rst), .set(row_set), .clr(row_clr),
    .set_row(row_val), .probe_row(req_addr[ROW_W+COL_W-1:COL_W]),
    .is_open(row_open), .hit(row_hit)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
    .T_RAC_NS(T_RAC_NS), .T_PC_NS(T_PC_NS), .T_AA_NS(T_AA_NS),
    .T_CAC_NS(T_CAC_NS), .T_CAS_NS(T_CAS_NS), .T_RP_NS(T_RP_NS),
    .T_RAS_NS(T_RAS_NS)
  ) i_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .ref_pend(ref_pend), .ref_ack(ref_ack),
    .row_open(row_open), .row_hit(row_hit), .row_set(row_set),
    .row_clr(row_clr), .row_val(row_val),
    .ras_n(mem_ras_n), .cas_n(cas_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  assign mem_casl_n = cas_n[0];
  assign mem_cash_n = cas_n[LANES-1];

endmodule

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int REF_GAP    = 16000000 / 1024 / CLK_PERIOD;
  localparam int REF_SLACK  = 40;
  localparam int CAS_MIN    = 2;   // ceil(25ns/10)-1, ceil(15/10), ceil(8/10) -> 2
  localparam int RP_MIN     = 3;   // ceil(30/10)
  localparam int RAC_MIN    = 5;   // ceil(50/10)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [9:0]  maddr;
  logic [15:0] dq_out;
  logic [15:0] dq_in = '0;

  int checks = 0, errors = 0;

  edo_dram_ctrl i_edo_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_ras_n(ras_n), .mem_casl_n(casl_n), .mem_cash_n(cash_n),
    .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_addr(maddr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  int m_row = 0, m_col = 0;
  int user_ras = 0, ref_seen = 0;

  function automatic logic [15:0] mrd(input int k);
    return mem.exists(k) ? mem[k] : 16'h0;
  endfunction
  function automatic logic [15:0] srd(input int k);
    return shadow.exists(k) ? shadow[k] : 16'h0;
  endfunction

  always @(negedge ras_n) begin
    if (casl_n && cash_n) begin
      m_row = int'(maddr);
      user_ras++;
    end else begin
      ref_seen++;
    end
  end

  always @(negedge casl_n or negedge cash_n) begin
    if (!ras_n) begin
      logic [15:0] w;
      int key;
      m_col = int'(maddr);
      key = m_row * 1024 + m_col;
      if (!we_n) begin
        w = mrd(key);
        if (!casl_n) w[7:0]  = dq_out[7:0];
        if (!cash_n) w[15:8] = dq_out[15:8];
        mem[key] = w;
      end else if (!oe_n) begin
        dq_in = mrd(key);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ---------------- per-clock monitor ----------------
  bit run_mon = 0;
  bit cur_both = 0;
  bit prev_ras = 1, prev_casl = 1, prev_cash = 1;
  int ras_hi = 100, cas_lo = 0, gap = 0, since_ras = 0;

  always @(negedge clk) begin
    if (run_mon) begin
      gap++;
      // R5: direction and enable exclusivity
      check(!(dq_oe && !oe_n) && !(!oe_n && !we_n), "R5 drive/enable", {dq_oe, oe_n, we_n}, 3'b010);
      // R5: write enable set up before a column strobe falls
      if (((prev_casl && !casl_n) || (prev_cash && !cash_n)) && !ras_n && dq_oe)
        check(!we_n, "R5 we setup", we_n, 0);
      // R4: joint lanes move together
      if (cur_both && !ras_n)
        check(casl_n == cash_n, "R4 strobes together", {casl_n, cash_n}, {casl_n, casl_n});
      // R6: reads use both lanes
      if (!oe_n && !(casl_n && cash_n))
        check(!casl_n && !cash_n, "R6 read lanes", {casl_n, cash_n}, 0);
      // refresh and row falls
      if (prev_ras && !ras_n) begin
        if (!casl_n) begin
          check(gap <= REF_GAP + REF_SLACK, "R9 refresh interval", gap, REF_GAP);
          check(!prev_casl && !prev_cash, "R9 cas before ras", {prev_casl, prev_cash}, 0);
          check(ras_hi >= RP_MIN, "R10 row closed before refresh", ras_hi, RP_MIN);
          gap = 0;
        end else begin
          check(ras_hi >= RP_MIN, "R8 precharge", ras_hi, RP_MIN);
        end
      end
      if (gap > REF_GAP + REF_SLACK) begin
        check(0, "R9 refresh missing", gap, REF_GAP);
        gap = 0;
      end
      // R11: strobe width and access from row
      if (!ras_n && casl_n && !cash_n == 0 && (!prev_casl || !prev_cash) && casl_n && cash_n)
        check(cas_lo >= CAS_MIN, "R11 cas width", cas_lo, CAS_MIN);
      if (rd_valid)
        check(since_ras >= RAC_MIN, "R11 row access", since_ras, RAC_MIN);
      cas_lo    = (!casl_n || !cash_n) ? cas_lo + 1 : 0;
      ras_hi    = ras_n ? ras_hi + 1 : 0;
      since_ras = (prev_ras && !ras_n) ? 1 : since_ras + 1;
    end
    prev_ras  = ras_n;
    prev_casl = casl_n;
    prev_cash = cash_n;
  end

  // ---------------- request tasks ----------------
  task automatic do_op(input bit we, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    int key;
    logic [15:0] exp;
    key = int'(a[19:10]) * 1024 + int'(a[9:0]);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    cur_both = we ? (be == 2'b11) : 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      exp = srd(key);
      if (be[0]) exp[7:0]  = d[7:0];
      if (be[1]) exp[15:8] = d[15:8];
      shadow[key] = exp;
      for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
      check(req_ready, "R3 write completes", req_ready, 1);
    end else begin
      for (int i = 0; i < 100 && !rd_valid; i++) @(negedge clk);
      check(rd_valid && rd_data == srd(key), "R3 R6 read data", rd_data, srd(key));
      @(negedge clk);
      check(!rd_valid, "R6 single pulse", rd_valid, 0);
    end
    if (!we || be != 2'b00) begin
      check(m_row == int'(a[19:10]), "R2 row address", m_row, a[19:10]);
      check(m_col == int'(a[9:0]), "R2 column address", m_col, a[9:0]);
    end
    cur_both = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    int r0, r1, base;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (4) @(negedge clk);
    check(ras_n && casl_n && cash_n && we_n && oe_n && !dq_oe && !rd_valid,
          "R1 reset outputs", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && ras_n && casl_n && cash_n, "R1 ready after reset",
          {req_ready, ras_n, casl_n, cash_n}, 4'hF);
    run_mon = 1;

    // align with a refresh so the page checks see no refresh in between
    while (ref_seen == 0) @(negedge clk);
    repeat (10) @(negedge clk);
    r0 = ref_seen;
    base = user_ras;
    do_op(1, {10'd5, 10'd17}, 16'hA5C3, 2'b11);
    do_op(0, {10'd5, 10'd17}, 16'h0, 2'b00);
    do_op(1, {10'd5, 10'd17}, 16'h5A5A, 2'b01);   // R3 low byte only
    do_op(0, {10'd5, 10'd17}, 16'h0, 2'b00);
    do_op(1, {10'd5, 10'd17}, 16'h7E00, 2'b10);   // R3 high byte only
    do_op(0, {10'd5, 10'd17}, 16'h0, 2'b00);
    do_op(1, {10'd5, 10'd17}, 16'hFFFF, 2'b00);   // R3 no lanes: no change
    do_op(0, {10'd5, 10'd17}, 16'h0, 2'b00);
    do_op(0, {10'd5, 10'd900}, 16'h0, 2'b00);
    if (ref_seen == r0)
      check(user_ras - base == 1, "R7 page hits keep row", user_ras - base, 1);
    r1 = user_ras;
    do_op(1, {10'd1023, 10'd3}, 16'h1234, 2'b11);
    if (ref_seen == r0)
      check(user_ras - r1 == 1, "R8 row miss reopens", user_ras - r1, 1);
    do_op(0, {10'd1023, 10'd3}, 16'h0, 2'b00);
    do_op(0, {10'd5, 10'd17}, 16'h0, 2'b00);

    // back-to-back mixed traffic over few rows (R10 priority under load)
    for (int n = 0; n < 600; n++) begin
      logic [9:0] row;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: row = 10'd0;
        2'd1: row = 10'd1;
        2'd2: row = 10'd5;
        default: row = 10'd1023;
      endcase
      do_op(lfsr[2], {row, 4'd0, lfsr[13:8]}, lfsr[31:16], lfsr[4:3]);
    end

    r0 = ref_seen;
    repeat (REF_GAP + REF_SLACK) @(negedge clk);
    check(ref_seen > r0, "R9 idle refresh", ref_seen - r0, 1);
    check(ref_seen >= ($time / CLK_PERIOD) / (REF_GAP + REF_SLACK) - 1,
          "R10 refresh count", ref_seen, ($time / CLK_PERIOD) / (REF_GAP + REF_SLACK));
    finish_run();
  end

endmodule